// File: doc/BRIEF.md
# UART Frame Transmitter

This block serialises bytes into asynchronous start/data/parity/stop frames on a single output line. Bytes are pushed into a 16-entry transmit queue. The frame format comes from a mode word written through a simple write strobe. That word selects the character length, the parity rule and the number of stop bits. A separate control word turns the transmitter on or off, flushes its logic, and raises or drops a break condition on the line.

Bit timing comes from an external baud-tick strobe. Every serial bit lasts sixteen ticks. The frame format is captured when a frame starts, so a mode write takes effect on the next character.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset the line is idle high, the queue is empty and not full, the transmitter is disabled, and the mode is 8 data bits, no parity, one stop bit.
- R2: Mode bits [2:1] set the character length: 10 gives 7 bits, 11 gives 6 bits, and 00 or 01 gives 8 bits. Only the low bits of the byte are sent, least significant bit first.
- R3: Mode bits [5:3] set the parity bit that follows the data: 000 even, 001 odd, 010 always 0, 011 always 1, and 1xx no parity bit.
- R4: Mode bit 7 set sends two high stop bits; clear sends one.
- R5: The queue holds 16 bytes in order and reports full and empty. A push while full is dropped.
- R6: A frame opens with a low start bit, every bit lasts 16 baud ticks, and the line rests high between frames.
- R7: Control bit 4 enables the transmitter and control bit 5 disables it. While disabled no new frame starts, but a frame already in progress completes.
- R8: A control write with bits 4 and 5 both set leaves the transmitter disabled.
- R9: Control bit 1 acts as a one-shot. It empties the queue and abandons any frame, so the line is high in the second cycle after the write.
- R10: Control bit 7 requests a break and control bit 8 cancels it; if both are set, cancel wins. The line is driven low from the next frame boundary until the cancel, and then returns high.
- R11: The format is latched when a frame starts. A mode write during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word (bits 1, 4, 5, 7, 8 used) |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Mode word (length, parity, stop fields) |
| push_valid | input | 1 | Push a byte into the queue |
| push_data | input | 8 | Byte to push |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe and that nothing else drives the line state between ticks. The bench therefore toggles the tick on alternate cycles and never holds it high. The assertions also assume that pushes and register writes are single-cycle strobes. The bench drives each of them for exactly one cycle at a falling clock edge. Mode writes are made only while the line is idle, except in the one test that targets format latching.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int CTL_RST     = 1;
  localparam int CTL_EN      = 4;
  localparam int CTL_DIS     = 5;
  localparam int CTL_BRK_ON  = 7;
  localparam int CTL_BRK_OFF = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BRK, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic       stop2;
    logic [2:0] par;
    logic [1:0] len;
  } fmt_t;

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    case (len)
      2'b10:   char_bits = 4'd7;
      2'b11:   char_bits = 4'd6;
      default: char_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sft_fifo.sv
module sft_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem[rp_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R5
  AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> empty_o); // R9

endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [8:0] ctl_wdata_i,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  output logic       en_o,
  output logic       brk_o,
  output logic       flush_o,
  output fmt_t       fmt_o
);
  logic en_d, brk_d, flush_d;
  fmt_t fmt_d;
  logic unused_bits;

  assign unused_bits = ^{ctl_wdata_i[6], ctl_wdata_i[3:2], ctl_wdata_i[0],
                         mode_wdata_i[6], mode_wdata_i[0]};

  always_comb begin
    en_d    = en_o;
    brk_d   = brk_o;
    fmt_d   = fmt_o;
    flush_d = ctl_we_i && ctl_wdata_i[CTL_RST];
    if (ctl_we_i) begin
      if (ctl_wdata_i[CTL_DIS])          en_d = 1'b0;
      else if (ctl_wdata_i[CTL_EN])      en_d = 1'b1;
      if (ctl_wdata_i[CTL_BRK_OFF])      brk_d = 1'b0;
      else if (ctl_wdata_i[CTL_BRK_ON])  brk_d = 1'b1;
    end
    if (mode_we_i) begin
      fmt_d.len   = mode_wdata_i[2:1];
      fmt_d.par   = mode_wdata_i[5:3];
      fmt_d.stop2 = mode_wdata_i[7];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      brk_o   <= 1'b0;
      flush_o <= 1'b0;
      fmt_o   <= '{stop2: 1'b0, par: 3'b100, len: 2'b00};
    end else begin
      en_o    <= en_d;
      brk_o   <= brk_d;
      flush_o <= flush_d;
      fmt_o   <= fmt_d;
    end
  end

  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[CTL_DIS]) |=> !en_o); // R8
  AST_BREAK_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (brk_o && !(ctl_we_i && ctl_wdata_i[CTL_BRK_OFF])) |=> brk_o); // R10

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          brk_i,
  input  logic          flush_i,
  input  fmt_t          fmt_i,
  input  logic          empty_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          txd_o
);
  localparam int TCW = $clog2(TPB);
  localparam int BCW = $clog2(DW);

  tx_state_e      state_q, state_d;
  logic [TCW-1:0] tcnt_q, tcnt_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [DW-1:0]  shreg_q, shreg_d;
  fmt_t           fmt_q, fmt_d;
  logic           par_q, par_d, stop_q, stop_d;
  logic [DW-1:0]  ld_mask, ld_data;
  logic           ld_par, bit_end, last_bit;

  always_comb begin
    for (int i = 0; i < DW; i++) ld_mask[i] = (i < int'(char_bits(fmt_i.len)));
  end
  assign ld_data  = data_i & ld_mask;
  assign ld_par   = fmt_i.par[1] ? fmt_i.par[0] : ((^ld_data) ^ fmt_i.par[0]);
  assign bit_end  = tick_i && (tcnt_q == TCW'(TPB - 1));
  assign last_bit = ({1'b0, bit_q} == (BCW + 1)'(char_bits(fmt_q.len) - 4'd1));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    fmt_d   = fmt_q;
    par_d   = par_q;
    stop_d  = stop_q;
    pop_o   = 1'b0;
    if (flush_i) begin
      state_d = ST_IDLE;
      tcnt_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (brk_i) begin
            state_d = ST_BRK;
          end else if (en_i && !empty_i) begin
            pop_o   = 1'b1;
            shreg_d = ld_data;
            fmt_d   = fmt_i;
            par_d   = ld_par;
            tcnt_d  = '0;
            state_d = ST_START;
          end
        end
        ST_BRK: if (!brk_i) state_d = ST_IDLE;
        default: begin
          if (tick_i) tcnt_d = bit_end ? '0 : tcnt_q + 1'b1;
          if (bit_end) begin
            case (state_q)
              ST_START: begin
                state_d = ST_DATA;
                bit_d   = '0;
              end
              ST_DATA: begin
                shreg_d = shreg_q >> 1;
                bit_d   = bit_q + 1'b1;
                if (last_bit) begin
                  state_d = fmt_q.par[2] ? ST_STOP : ST_PAR;
                  stop_d  = 1'b0;
                end
              end
              ST_PAR: begin
                state_d = ST_STOP;
                stop_d  = 1'b0;
              end
              ST_STOP: begin
                if (fmt_q.stop2 && !stop_q) stop_d  = 1'b1;
                else                        state_d = ST_IDLE;
              end
              default: state_d = ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      fmt_q   <= '0;
      par_q   <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      fmt_q   <= fmt_d;
      par_q   <= par_d;
      stop_q  <= stop_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_BRK, ST_START: txd_o = 1'b0;
      ST_DATA:          txd_o = shreg_q[0];
      ST_PAR:           txd_o = par_q;
      default:          txd_o = 1'b1;
    endcase
  end

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) == ST_IDLE) |-> ($past(en_i) && !$past(brk_i))); // R7
  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q inside {ST_START, ST_DATA, ST_PAR, ST_STOP}) && !tick_i && !flush_i)
      |=> $stable(txd_o)); // R6
  AST_BREAK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && brk_i && !flush_i) |=> !txd_o); // R10

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import sft_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TPB   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [8:0] ctl_wdata,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  input  logic       baud_tick,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic       txd
);
  localparam int DW = 8;

  logic [1:0]    rsync_q;
  logic          rst_ni;
  logic          en, brk, flush, pop;
  fmt_t          fmt;
  logic [DW-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  sft_ctrl u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .ctl_we_i     (ctl_we),
    .ctl_wdata_i  (ctl_wdata),
    .mode_we_i    (mode_we),
    .mode_wdata_i (mode_wdata),
    .en_o         (en),
    .brk_o        (brk),
    .flush_o      (flush),
    .fmt_o        (fmt)
  );

  sft_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push_valid),
    .wdata_i (push_data),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  sft_shifter #(.DW(DW), .TPB(TPB)) u_shift (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick),
    .en_i    (en),
    .brk_i   (brk),
    .flush_i (flush),
    .fmt_i   (fmt),
    .empty_i (fifo_empty),
    .data_i  (head),
    .pop_o   (pop),
    .txd_o   (txd)
  );

endmodule

// File: tb/ser_frame_tx_bench.sv
module ser_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [8:0] ctl_wdata = '0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       baud_tick = 1'b0;
  logic       fifo_full, fifo_empty, txd;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  mode_cur = 8'h20;
  logic        mon_on = 1'b1;
  logic        mon_busy = 1'b0;
  logic        done = 1'b0;

  ser_frame_tx u_ser_frame_tx (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .push_valid(push_valid),
    .push_data(push_data), .baud_tick(baud_tick), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .txd(txd)
  );

  always #5 clk = ~clk;
  always @(posedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [8:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic mode_write(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v; mode_cur = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic push_raw(input logic [7:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic push_exp(input logic [7:0] d);
    exp_q.push_back({mode_cur, d});
    push_raw(d);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  task automatic quiet_for(input int n, input string what);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk(what, lows, 0);
  endtask

  // Scoreboard monitor: decodes each frame at bit centres
  always begin
    @(negedge clk);
    if (mon_on && txd === 1'b0 && exp_q.size() != 0) begin
      logic [15:0] it;
      logic [7:0]  m, d;
      int nb, p;
      it = exp_q.pop_front();
      mon_busy = 1'b1;
      m = it[15:8];
      d = it[7:0];
      nb = (m[2:1] == 2'b10) ? 7 : (m[2:1] == 2'b11) ? 6 : 8;
      repeat (16) @(negedge clk);
      chk("R6 start bit", int'(txd), 0);
      for (int i = 0; i < nb; i++) begin
        repeat (32) @(negedge clk);
        chk("R2 data bit", int'(txd), int'(d[i]));
      end
      if (!m[5]) begin
        p = 0;
        for (int i = 0; i < nb; i++) p = p ^ int'(d[i]);
        if (m[4]) p = int'(m[3]);
        else      p = p ^ int'(m[3]);
        repeat (32) @(negedge clk);
        chk("R3 parity bit", int'(txd), p);
      end
      repeat (32) @(negedge clk);
      chk("R4 stop bit", int'(txd), 1);
      if (m[7]) begin
        repeat (32) @(negedge clk);
        chk("R4 second stop bit", int'(txd), 1);
      end
      mon_busy = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 txd idle", int'(txd), 1);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);

    // R7 disabled after reset: byte waits
    push_exp(8'hA5);
    quiet_for(300, "R7 no frame while disabled");
    chk("R7 byte still queued", int'(fifo_empty), 0);
    // R8 enable and disable together
    ctl_write(9'h030);
    quiet_for(300, "R8 both bits leave disabled");
    ctl_write(9'h010);
    drain();

    // R2 R3 R4 formats
    push_exp(8'h55); push_exp(8'h80); drain();
    mode_write(8'h04); push_exp(8'hFF); push_exp(8'h2A); drain();
    mode_write(8'h0E); push_exp(8'hC5); push_exp(8'h3F); drain();
    mode_write(8'h10); push_exp(8'hFF); drain();
    mode_write(8'h18); push_exp(8'h00); drain();
    mode_write(8'h8C); push_exp(8'h61); push_exp(8'h7E); drain();
    mode_write(8'hA6); push_exp(8'h15); drain();
    mode_write(8'h02); push_exp(8'h96); drain();

    // R11 mode write mid-frame does not disturb the frame
    mode_write(8'h20);
    push_exp(8'h3C);
    while (!mon_busy) @(negedge clk);
    repeat (40) @(negedge clk);
    mode_write(8'h0E);
    mode_cur = 8'h20;
    drain();
    chk("R11 frame finished", int'(fifo_empty), 1);
    mode_write(8'h20);

    // R5 fill to 16, drop the 17th
    ctl_write(9'h020);
    for (int i = 0; i < 16; i++) push_exp(8'(i * 17 + 3));
    chk("R5 full at 16", int'(fifo_full), 1);
    chk("R5 not empty", int'(fifo_empty), 0);
    push_raw(8'hEE);
    chk("R5 still full after drop", int'(fifo_full), 1);
    ctl_write(9'h010);
    drain();
    quiet_for(500, "R5 dropped byte not sent");
    chk("R5 empty after drain", int'(fifo_empty), 1);

    // R7 disable mid-frame: current frame completes, next waits
    push_exp(8'h11);
    push_raw(8'h22);
    while (!mon_busy) @(negedge clk);
    repeat (40) @(negedge clk);
    ctl_write(9'h020);
    drain();
    quiet_for(400, "R7 no new frame after disable");
    chk("R7 second byte kept", int'(fifo_empty), 0);
    // R9 flush
    ctl_write(9'h002);
    repeat (1) @(negedge clk);
    chk("R9 flush empties queue", int'(fifo_empty), 1);
    ctl_write(9'h010);
    quiet_for(300, "R9 flushed bytes not sent");

    // R9 abandon a frame in progress
    mon_on = 1'b0;
    push_raw(8'h00);
    repeat (100) @(negedge clk);
    chk("R9 mid-frame line low", int'(txd), 0);
    ctl_write(9'h002);
    repeat (2) @(negedge clk);
    chk("R9 line high after flush", int'(txd), 1);
    quiet_for(200, "R9 frame abandoned");
    mon_on = 1'b1;

    // R10 break at idle, cancel, and cancel winning
    ctl_write(9'h080);
    repeat (2) @(negedge clk);
    chk("R10 break low", int'(txd), 0);
    repeat (200) @(negedge clk);
    chk("R10 break held", int'(txd), 0);
    ctl_write(9'h100);
    repeat (2) @(negedge clk);
    chk("R10 idle after cancel", int'(txd), 1);
    ctl_write(9'h180);
    quiet_for(50, "R10 cancel wins");

    // R10 break requested mid-frame waits for the boundary
    push_exp(8'h5A);
    while (!mon_busy) @(negedge clk);
    repeat (50) @(negedge clk);
    ctl_write(9'h080);
    drain();
    repeat (40) @(negedge clk);
    chk("R10 low after frame", int'(txd), 0);
    ctl_write(9'h100);
    repeat (2) @(negedge clk);
    chk("R10 high after cancel", int'(txd), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule